// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block collects sixty-four active-low request inputs into a single processor interrupt line. Software sees the sources through two 32-bit register words, a high word and a low word. Each source owns one bit in one word, and the assignment follows a fixed, non-linear map. The same map is used for the enable masks and for the pending latches. A read-only vector register names the winning source, so a handler can find its cause with one read.

Each input is synchronised before it is used. Most inputs are sensed as low levels. Two pin groups can be reconfigured through a sense register. The external group (sources 19 to 25) chooses between low level and falling edge. The port group (sources 48 to 63) chooses between both edges and falling edge only. Pending bits are cleared by writing ones. Source 0 is reserved, so a vector value of zero means that nothing is being requested.

Top module: `irq_gather64`

## Requirements
- R1: After reset, both mask words, both pending words and the sense register read zero, the vector reads zero and `irq` is low.
- R2: Source s maps to a word and a bit position as follows. s=0 goes to high bit 0. s=1..15 go to high bit 16-s. s=16..31 go to low bit 31-s. s=32..47 go to high bit 63-s. s=48..63 go to low bit s-32. The mask words and the pending words use the same map.
- R3: The register word addresses are: 0 for the vector, 1 for mask high, 2 for mask low, 3 for pending high, 4 for pending low and 5 for sense. Reads of any other address return zero. Writes to any other address, and writes to the vector, change no register.
- R4: A mask bit of 1 enables its source. `irq` is high exactly when some source is both pending and enabled.
- R5: A pending bit latches whether or not its mask bit is set. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R6: If a request arrives in the same cycle as a clearing write to its pending bit, the bit stays set.
- R7: The vector read returns the lowest-numbered source that is pending and enabled, placed in bits 31:26, with bits 25:0 zero. It reads zero when no source qualifies.
- R8: A level-sensed source sets its pending bit again on every clock while its input is low. A clear only holds once the input has returned high.
- R9: External sources 19..25 use sense bit 33-s. A value of 1 selects falling-edge sensing, which sets the pending bit once per edge. A value of 0 selects low-level sensing.
- R10: Port sources 48..63 use sense bit s-32. A value of 1 detects falling edges only. A value of 0 detects both rising and falling edges.
- R11: Only sense bits 8..14 and 16..31 hold written values. The other sense bits always read zero.
- R12: Source 0 never becomes pending, whatever its input does.
- R13: An input change that is driven between clock edges shows up in its pending bit after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_n | input | 64 | Raw request inputs, active low, asynchronous |
| irq | output | 1 | Interrupt line to the processor |

## Verification
Two functions can meet in one clock edge: an edge detection that sets a pending bit, and a software write of one that clears the same bit. The bench provokes this on a falling-edge port source that is already pending. It times the clearing write so that it lands on the exact edge where the new falling edge reaches the pending latch. The pass condition is that the bit reads back as still set. A plain clear on a later edge, with the input held low, is then checked to leave the bit at zero.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    localparam int NUM_SRC    = 64;
    localparam int DATA_W     = 32;
    localparam int VEC_W      = 6;
    localparam int VEC_LSB    = DATA_W - VEC_W;
    localparam int EXT_FIRST  = 19;
    localparam int EXT_LAST   = 25;
    localparam int PORT_FIRST = 48;
    localparam int PORT_LAST  = 63;

    // sense register bits that are backed by storage
    localparam logic [DATA_W-1:0] SENSE_IMPL = 32'hFFFF_7F00;

    typedef enum logic [3:0] {
        RA_VECTOR  = 4'd0,
        RA_MASK_HI = 4'd1,
        RA_MASK_LO = 4'd2,
        RA_PEND_HI = 4'd3,
        RA_PEND_LO = 4'd4,
        RA_SENSE   = 4'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        GRP_RESERVED,
        GRP_LEVEL,
        GRP_EXT,
        GRP_PORT
    } sense_grp_e;

    typedef struct packed {
        logic       hi;
        logic [4:0] pos;
    } slot_t;

    // word/bit placement of a source number
    function automatic slot_t src_slot(input int s);
        slot_t r;
        if (s == 0) begin
            r.hi  = 1'b1;
            r.pos = 5'd0;
        end else if (s < 16) begin
            r.hi  = 1'b1;
            r.pos = 5'(16 - s);
        end else if (s < 32) begin
            r.hi  = 1'b0;
            r.pos = 5'(31 - s);
        end else if (s < 48) begin
            r.hi  = 1'b1;
            r.pos = 5'(63 - s);
        end else begin
            r.hi  = 1'b0;
            r.pos = 5'(s - 32);
        end
        return r;
    endfunction

    function automatic sense_grp_e src_group(input int s);
        if (s == 0)
            return GRP_RESERVED;
        else if (s >= EXT_FIRST && s <= EXT_LAST)
            return GRP_EXT;
        else if (s >= PORT_FIRST && s <= PORT_LAST)
            return GRP_PORT;
        else
            return GRP_LEVEL;
    endfunction

    // sense register bit controlling a configurable source
    function automatic int sense_pos(input int s);
        if (s >= EXT_FIRST && s <= EXT_LAST)
            return 33 - s;
        else if (s >= PORT_FIRST && s <= PORT_LAST)
            return s - 32;
        else
            return 0;
    endfunction

endpackage

// File: rtl/irq_src_front.sv
module irq_src_front
    import irq_gather_pkg::*;
#(
    parameter int NSRC        = NUM_SRC,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_n,
    input  logic [DATA_W-1:0] sense,
    output logic [NSRC-1:0]   req
);

    logic [NSRC-1:0] sync_v;
    logic [NSRC-1:0] prev_v;
    logic [NSRC-1:0] fall_v;
    logic [NSRC-1:0] rise_v;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam sense_grp_e GRP = src_group(s);
        localparam int         SP  = sense_pos(s);

        logic [SYNC_STAGES-1:0] chain_q;
        logic                   prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], src_n[s]};
                prev_q  <= chain_q[SYNC_STAGES-1];
            end
        end

        assign sync_v[s] = chain_q[SYNC_STAGES-1];
        assign prev_v[s] = prev_q;
        assign fall_v[s] = prev_q & ~chain_q[SYNC_STAGES-1];
        assign rise_v[s] = ~prev_q & chain_q[SYNC_STAGES-1];

        if (GRP == GRP_RESERVED) begin : g_rsv
            assign req[s] = 1'b0;
        end else if (GRP == GRP_EXT) begin : g_ext
            assign req[s] = sense[SP] ? fall_v[s] : ~sync_v[s];
        end else if (GRP == GRP_PORT) begin : g_port
            assign req[s] = sense[SP] ? fall_v[s] : (fall_v[s] | rise_v[s]);
        end else begin : g_lvl
            assign req[s] = ~sync_v[s];
        end
    end

    logic unused_front;
    assign unused_front = ^{sync_v, prev_v, fall_v, rise_v, sense};

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);

    logic [NSRC-1:0] pend_q;

    // a new request overrides a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | req;
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC  = 64,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  active,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);

    // lowest index wins: scan downward, last hit stays
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_gather64.sv
module irq_gather64
    import irq_gather_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_n,
    output logic              irq
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic sel_vec, sel_mhi, sel_mlo, sel_phi, sel_plo, sel_sense;

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] req_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] mwr_v;
    logic [NUM_SRC-1:0] wbit_v;

    logic [DATA_W-1:0] mask_hi_w, mask_lo_w, pend_hi_w, pend_lo_w;
    logic [DATA_W-1:0] sense_q;
    logic [DATA_W-1:0] vec_w;

    logic [IDX_W-1:0] win_idx;
    logic             win_vld;

    assign sel_vec   = (bus_addr == ADDR_W'(RA_VECTOR));
    assign sel_mhi   = (bus_addr == ADDR_W'(RA_MASK_HI));
    assign sel_mlo   = (bus_addr == ADDR_W'(RA_MASK_LO));
    assign sel_phi   = (bus_addr == ADDR_W'(RA_PEND_HI));
    assign sel_plo   = (bus_addr == ADDR_W'(RA_PEND_LO));
    assign sel_sense = (bus_addr == ADDR_W'(RA_SENSE));

    // per-source placement into the two register words
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        localparam slot_t SL = src_slot(s);

        assign wbit_v[s] = bus_wdata[SL.pos];

        if (SL.hi) begin : g_hi
            assign mask_hi_w[SL.pos] = mask_q[s];
            assign pend_hi_w[SL.pos] = pend_q[s];
            assign mwr_v[s]          = bus_we & sel_mhi;
            assign clr_v[s]          = bus_we & sel_phi & bus_wdata[SL.pos];
        end else begin : g_lo
            assign mask_lo_w[SL.pos] = mask_q[s];
            assign pend_lo_w[SL.pos] = pend_q[s];
            assign mwr_v[s]          = bus_we & sel_mlo;
            assign clr_v[s]          = bus_we & sel_plo & bus_wdata[SL.pos];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            sense_q <= '0;
        end else begin
            mask_q <= (mask_q & ~mwr_v) | (mwr_v & wbit_v);
            if (bus_we && sel_sense)
                sense_q <= bus_wdata & SENSE_IMPL;
        end
    end

    irq_src_front #(
        .NSRC        (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk   (clk),
        .rst   (rst),
        .src_n (src_n),
        .sense (sense_q),
        .req   (req_v)
    );

    irq_pend_bank #(
        .NSRC (NUM_SRC)
    ) u_pend (
        .clk  (clk),
        .rst  (rst),
        .req  (req_v),
        .clr  (clr_v),
        .pend (pend_q)
    );

    irq_prio_pick #(
        .NSRC  (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .active (pend_q & mask_q),
        .idx    (win_idx),
        .vld    (win_vld)
    );

    assign vec_w = win_vld ? {VEC_W'(win_idx), {VEC_LSB{1'b0}}} : '0;
    assign irq   = win_vld;

    always_comb begin
        bus_rdata = '0;
        if (sel_vec)   bus_rdata = vec_w;
        if (sel_mhi)   bus_rdata = mask_hi_w;
        if (sel_mlo)   bus_rdata = mask_lo_w;
        if (sel_phi)   bus_rdata = pend_hi_w;
        if (sel_plo)   bus_rdata = pend_lo_w;
        if (sel_sense) bus_rdata = sense_q;
    end

endmodule

// File: rtl/irq_gather64_chk.sv
module irq_gather64_chk
    import irq_gather_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] req_v
);

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > ADDR_W'(RA_SENSE)) |-> (bus_rdata == '0));

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((mask_q != '0) && (pend_q != '0)));

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (req_v != '0) |=> ((pend_q & $past(req_v)) == $past(req_v)));

    assert_vec_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(RA_VECTOR)) |-> (bus_rdata[VEC_LSB-1:0] == '0));

    assert_vec_tracks_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(RA_VECTOR)) |-> ((bus_rdata[DATA_W-1:VEC_LSB] != '0) == irq));

    assert_sense_unimpl_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(RA_SENSE)) |-> ((bus_rdata & ~SENSE_IMPL) == '0));

    assert_src0_reserved_R12: assert property (@(posedge clk) disable iff (rst)
        !pend_q[0]);

endmodule

bind irq_gather64 irq_gather64_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .req_v     (req_v)
);

// File: tb/irq_gather64_tb_top.sv
module irq_gather64_tb_top;
    import irq_gather_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [63:0] src_n = '1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_gather64 dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_n     (src_n),
        .irq       (irq)
    );

    // {source[5:0], high word, bit position[4:0]} for level-sensed sources
    localparam logic [11:0] MAP_TBL [11] = '{
        {6'd1,  1'b1, 5'd15},
        {6'd5,  1'b1, 5'd11},
        {6'd15, 1'b1, 5'd1},
        {6'd16, 1'b0, 5'd15},
        {6'd18, 1'b0, 5'd13},
        {6'd23, 1'b0, 5'd8},
        {6'd30, 1'b0, 5'd1},
        {6'd31, 1'b0, 5'd0},
        {6'd32, 1'b1, 5'd31},
        {6'd40, 1'b1, 5'd23},
        {6'd47, 1'b1, 5'd16}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic pin(input int s, input logic v);
        @(negedge clk);
        src_n[s] = v;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic clear_all();
        settle();
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int          s;
        logic        hi;
        logic [31:0] bitv;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_rd("R1 reset reg", 4'(a), 32'd0);
        check("R1 irq low", {31'd0, irq}, 32'd0);

        // R3 unmapped addresses and vector writes
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        for (int a = 1; a < 6; a++) chk_rd("R3 regs untouched", 4'(a), 32'd0);
        chk_rd("R3 unmapped read 6", 4'd6, 32'd0);
        chk_rd("R3 unmapped read 15", 4'd15, 32'd0);

        // R11 sense storage
        wr(4'd5, 32'hFFFF_FFFF);
        chk_rd("R11 sense implemented bits", 4'd5, 32'hFFFF_7F00);
        wr(4'd5, 32'd0);

        // R2 R7 R8 mapping table walk with all sources enabled
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        for (int i = 0; i < 11; i++) begin
            s    = int'(MAP_TBL[i][11:6]);
            hi   = MAP_TBL[i][5];
            bitv = 32'd1 << MAP_TBL[i][4:0];
            pin(s, 1'b0);
            settle();
            chk_rd($sformatf("R2 src %0d high word", s), 4'd3, hi ? bitv : 32'd0);
            chk_rd($sformatf("R2 src %0d low word", s), 4'd4, hi ? 32'd0 : bitv);
            chk_rd($sformatf("R7 src %0d vector", s), 4'd0, {6'(s), 26'd0});
            pin(s, 1'b1);
            clear_all();
            chk_rd($sformatf("R8 src %0d cleared after release", s), hi ? 4'd3 : 4'd4, 32'd0);
        end

        // R4 R5 mask gating and write-one-to-clear; source 3 -> high bit 13
        wr(4'd1, 32'd0);
        wr(4'd2, 32'd0);
        pin(3, 1'b0);
        settle();
        chk_rd("R5 pends while masked", 4'd3, 32'h0000_2000);
        check("R4 masked irq low", {31'd0, irq}, 32'd0);
        wr(4'd1, 32'h0000_2000);
        chk_rd("R2 mask high bit13", 4'd1, 32'h0000_2000);
        check("R4 enabled irq high", {31'd0, irq}, 32'd1);
        chk_rd("R7 vector src3", 4'd0, {6'd3, 26'd0});
        pin(3, 1'b1);
        settle();
        wr(4'd3, 32'd0);
        chk_rd("R5 write zero keeps", 4'd3, 32'h0000_2000);
        wr(4'd3, 32'h0000_2000);
        chk_rd("R5 write one clears", 4'd3, 32'd0);
        check("R4 irq drops", {31'd0, irq}, 32'd0);

        // R8 level source re-pends while held low; source 7 -> high bit 9
        pin(7, 1'b0);
        settle();
        wr(4'd3, 32'h0000_0200);
        chk_rd("R8 re-pend while low", 4'd3, 32'h0000_0200);
        pin(7, 1'b1);
        clear_all();
        chk_rd("R8 clear sticks", 4'd3, 32'd0);

        // R9 R13 external source 20: sense bit 13, low bit 11
        wr(4'd5, 32'h0000_2000);
        pin(20, 1'b0);
        @(posedge clk);
        @(posedge clk);
        chk_rd("R13 not yet after two edges", 4'd4, 32'd0);
        @(posedge clk);
        chk_rd("R13 pending after three edges", 4'd4, 32'h0000_0800);
        wr(4'd4, 32'h0000_0800);
        settle();
        chk_rd("R9 falling edge pends once", 4'd4, 32'd0);
        pin(20, 1'b1);
        settle();
        chk_rd("R9 rise ignored", 4'd4, 32'd0);
        wr(4'd5, 32'd0);
        settle();
        chk_rd("R9 level mode idle high", 4'd4, 32'd0);
        pin(20, 1'b0);
        settle();
        wr(4'd4, 32'h0000_0800);
        chk_rd("R9 level mode re-pends", 4'd4, 32'h0000_0800);
        pin(20, 1'b1);
        clear_all();

        // R10 port source 60: sense bit 28, low bit 28
        pin(60, 1'b0);
        settle();
        chk_rd("R10 both-edge fall", 4'd4, 32'h1000_0000);
        wr(4'd4, 32'h1000_0000);
        settle();
        chk_rd("R10 held low stays clear", 4'd4, 32'd0);
        pin(60, 1'b1);
        settle();
        chk_rd("R10 both-edge rise", 4'd4, 32'h1000_0000);
        wr(4'd4, 32'h1000_0000);
        wr(4'd5, 32'h1000_0000);
        pin(60, 1'b0);
        settle();
        chk_rd("R10 falling-only fall", 4'd4, 32'h1000_0000);
        wr(4'd4, 32'h1000_0000);
        pin(60, 1'b1);
        settle();
        chk_rd("R10 falling-only rise ignored", 4'd4, 32'd0);

        // R6 port source 50: sense bit 18, low bit 18; edge meets clear
        wr(4'd5, 32'h1004_0000);
        pin(50, 1'b0);
        settle();
        pin(50, 1'b1);
        settle();
        chk_rd("R6 pre-pended", 4'd4, 32'h0004_0000);
        pin(50, 1'b0);
        @(posedge clk);
        @(posedge clk);
        wr(4'd4, 32'h0004_0000);
        chk_rd("R6 set wins over clear", 4'd4, 32'h0004_0000);
        wr(4'd4, 32'h0004_0000);
        chk_rd("R6 later clear holds", 4'd4, 32'd0);
        pin(50, 1'b1);
        clear_all();

        // R7 priority: sources 10 (high bit 6) and 40 (high bit 23)
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        pin(10, 1'b0);
        pin(40, 1'b0);
        settle();
        chk_rd("R7 lowest number wins", 4'd0, {6'd10, 26'd0});
        wr(4'd1, 32'hFFFF_FFBF);
        chk_rd("R7 next after masking", 4'd0, {6'd40, 26'd0});
        check("R4 irq with src40", {31'd0, irq}, 32'd1);
        pin(10, 1'b1);
        pin(40, 1'b1);
        clear_all();
        chk_rd("R7 vector empty", 4'd0, 32'd0);

        // R12 source 0 reserved
        pin(0, 1'b0);
        settle();
        settle();
        chk_rd("R12 src0 never pends", 4'd3, 32'd0);
        check("R12 irq low", {31'd0, irq}, 32'd0);
        pin(0, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule